// File: doc/BRIEF.md
# Ethernet Transmit Frame Validator

This block sits between a software-filled transmit buffer and a byte-wide transmit path. Software first places a complete frame in the buffer: an 8-byte preamble and start delimiter, then the frame body, then a 4-byte frame check sequence. It then writes the total byte count to the count register. A nonzero count starts one attempt.

Each attempt first checks the count against a minimum and a maximum length. It then reads the first eight buffer bytes through a combinational read port and compares them with the expected preamble pattern. If both checks pass, the block streams only the frame body over a valid/ready byte stream. It skips the leading eight bytes and the trailing four, then clears the count register.

Every attempt, whether it streams or is rejected, ends with a one-cycle done pulse. A rejected attempt leaves the written count in place so software can read it back.

Top module: `tx_frame_validator`

## Requirements
- R1: A write of a nonzero value to the count register while the block is idle starts one attempt. A write of zero stores zero, which reads back on txCount, and starts nothing: no pulse and no stream.
- R2: A count below 64 is rejected. 64 itself is accepted.
- R3: A count above 1530 is rejected. 1530 itself is accepted.
- R4: The byte at buffer offset 7 must be 0xD5 and the bytes at offsets 0 to 6 must be 0x55. Any mismatch rejects the attempt.
- R5: On acceptance, outData carries the bytes at buffer offsets 8 up to count-5 in address order, which is count-12 bytes. A byte moves when outValid and outReady are both high at a clock edge. outLast is high with the final byte only. While outReady is low, outValid stays high and the presented byte does not change.
- R6: After the final byte has moved, txCount reads 0. After a rejection, txCount keeps the written value.
- R7: Every attempt ends with txDone high for exactly one cycle. A rejection on length shows txDone in the second cycle after the cycle in which the write was presented.
- R8: A count write made while an attempt is in progress, up to and including its done cycle, is ignored. The stored count is unchanged and no extra attempt follows.
- R9: After reset, txCount is 0 and outValid, outLast and txDone are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Count register write strobe |
| wrData | input | 16 | Count value to write |
| txCount | output | 16 | Count register readback |
| bufAddr | output | 11 | Transmit buffer byte address |
| bufData | input | 8 | Buffer byte at bufAddr, same cycle |
| outData | output | 8 | Streamed frame body byte |
| outValid | output | 1 | outData is valid |
| outLast | output | 1 | Final body byte |
| outReady | input | 1 | Downstream accepts the byte |
| txDone | output | 1 | One-cycle end-of-attempt pulse |

## Verification
A write is captured at one edge, and the preamble scan then takes one cycle per byte. A length rejection is therefore due exactly two cycles after the write is presented, and the bench checks that cycle and its neighbours on falling edges. A preamble mismatch at offset j is due j cycles later than a length rejection. Streamed bytes are due from the ninth cycle after capture onward, at a rate set by outReady. The bench therefore does not predict byte timing: it compares each presented byte, the outLast flag and the count of handshakes at every falling edge against the buffer image. The count readback and the number of done pulses are checked only after the pulse has been seen.

// File: rtl/tx_val_pkg.sv
package tx_val_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_SEND  = 2'd2,
    ST_DONE  = 2'd3
  } txState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCount;
    logic clearCount;
    logic resetIdx;
    logic stepIdx;
  } txCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic lenBad;
    logic byteBad;
    logic preDone;
    logic bodyLast;
  } txStat_t;

endpackage

// File: rtl/tx_val_datapath.sv
module tx_val_datapath
  import tx_val_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 11,
  parameter int MIN_LEN  = 64,
  parameter int MAX_LEN  = 1530,
  parameter int PRE_LEN  = 8,
  parameter int FCS_LEN  = 4,
  parameter logic [7:0] FILL_BYTE = 8'h55,
  parameter logic [7:0] SFD_BYTE  = 8'hD5
) (
  input  logic              clk,
  input  logic              rstN,
  input  txCtrl_t           ctrl,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [7:0]        bufData,
  output logic [CNT_W-1:0]  txCount,
  output logic [ADDR_W-1:0] bufAddr,
  output logic [7:0]        outData,
  output txStat_t           stat
);

  localparam logic [CNT_W-1:0] MIN_C    = CNT_W'(MIN_LEN);
  localparam logic [CNT_W-1:0] MAX_C    = CNT_W'(MAX_LEN);
  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_LEN - 1);
  localparam logic [CNT_W-1:0] TAIL_OFS = CNT_W'(FCS_LEN + 1);

  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] idxQ;
  logic [7:0]       expByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (ctrl.loadCount) begin
      countQ <= wrData;
    end else if (ctrl.clearCount) begin
      countQ <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.resetIdx) begin
      idxQ <= '0;
    end else if (ctrl.stepIdx) begin
      idxQ <= idxQ + 1'b1;
    end
  end

  always_comb begin
    expByte       = (idxQ == PRE_LAST) ? SFD_BYTE : FILL_BYTE;
    stat.lenBad   = (countQ < MIN_C) || (countQ > MAX_C);
    stat.byteBad  = (bufData != expByte);
    stat.preDone  = (idxQ == PRE_LAST);
    stat.bodyLast = (idxQ == countQ - TAIL_OFS);
  end

  assign txCount = countQ;
  assign bufAddr = idxQ[ADDR_W-1:0];
  assign outData = bufData;

  // R6: a clear strobe leaves the register at zero
  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.clearCount && !ctrl.loadCount) |=> (txCount == '0));

endmodule

// File: rtl/tx_val_control.sv
module tx_val_control
  import tx_val_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrEn,
  input  logic    wrNonZero,
  input  txStat_t stat,
  input  logic    outReady,
  output txCtrl_t ctrl,
  output logic    outValid,
  output logic    outLast,
  output logic    txDone,
  output logic    busy
);

  txState_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    ctrl   = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (wrEn) begin
          ctrl.loadCount = 1'b1;
          ctrl.resetIdx  = 1'b1;
          if (wrNonZero) stateD = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (stat.lenBad || stat.byteBad) begin
          stateD = ST_DONE;
        end else begin
          ctrl.stepIdx = 1'b1;
          if (stat.preDone) stateD = ST_SEND;
        end
      end
      ST_SEND: begin
        if (outReady) begin
          if (stat.bodyLast) begin
            ctrl.clearCount = 1'b1;
            stateD = ST_DONE;
          end else begin
            ctrl.stepIdx = 1'b1;
          end
        end
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  assign outValid = (stateQ == ST_SEND);
  assign outLast  = (stateQ == ST_SEND) && stat.bodyLast;
  assign txDone   = (stateQ == ST_DONE);
  assign busy     = (stateQ != ST_IDLE);

  // R7: the done pulse never lasts two cycles
  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    txDone |=> !txDone);

  // R5: last is only flagged on a presented byte
  a_r5_last_valid: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  // R6: the final handshake is followed by the pulse
  a_r6_final_then_done: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLast && outReady) |=> (txDone && !outValid));

endmodule

// File: rtl/tx_frame_validator.sv
module tx_frame_validator
  import tx_val_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 11,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1530,
  parameter int PRE_LEN = 8,
  parameter int FCS_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  txCount,
  output logic [ADDR_W-1:0] bufAddr,
  input  logic [7:0]        bufData,
  output logic [7:0]        outData,
  output logic              outValid,
  output logic              outLast,
  input  logic              outReady,
  output logic              txDone
);

  txCtrl_t ctrl;
  txStat_t stat;
  logic    busy;

  tx_val_datapath #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN),
    .PRE_LEN(PRE_LEN), .FCS_LEN(FCS_LEN)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .wrData(wrData), .bufData(bufData),
    .txCount(txCount), .bufAddr(bufAddr), .outData(outData), .stat(stat)
  );

  tx_val_control i_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrNonZero(|wrData), .stat(stat),
    .outReady(outReady), .ctrl(ctrl), .outValid(outValid), .outLast(outLast),
    .txDone(txDone), .busy(busy)
  );

  // R8: a write during an attempt leaves the count alone
  a_r8_busy_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn && !(outValid && outLast && outReady)) |=> $stable(txCount));

  // R5: a stalled byte stays presented at the same address
  a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(bufAddr)));

endmodule

// File: tb/test_tx_frame_validator.sv
module test_tx_frame_validator;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [15:0] wrData;
  logic [15:0] txCount;
  logic [10:0] bufAddr;
  logic [7:0]  bufData;
  logic [7:0]  outData;
  logic        outValid, outLast, outReady, txDone;

  logic [7:0] mem [0:2047];
  assign bufData = mem[bufAddr];

  always #4 clk = ~clk;

  tx_frame_validator i_tx_frame_validator (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .txCount(txCount),
    .bufAddr(bufAddr), .bufData(bufData), .outData(outData), .outValid(outValid),
    .outLast(outLast), .outReady(outReady), .txDone(txDone)
  );

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  // count, corrupted preamble offset (8 = none), expect send
  localparam int N_VEC = 8;
  localparam int VEC_CNT [N_VEC] = '{100, 64, 1530, 63, 1531, 100, 100, 100};
  localparam int VEC_BAD [N_VEC] = '{8,   8,  8,    8,  8,    0,   7,   3};
  localparam int VEC_OK  [N_VEC] = '{1,   1,  1,    0,  0,    0,   0,   0};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic fillBuf();
    for (int i = 0; i < 2048; i++) mem[i] = 8'((i * 13 + 5) & 255);
    for (int i = 0; i < 7; i++) mem[i] = 8'h55;
    mem[7] = 8'hD5;
  endtask

  task automatic writeCount(input int v);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = 16'(v);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  int got, mism, lastErr, pulses;

  task automatic runFrame(input int cnt, input int corrupt, input bit midWrite);
    int cyc;
    bit doneSeen;
    fillBuf();
    if (corrupt < 8) mem[corrupt] = mem[corrupt] ^ 8'h01;
    got = 0; mism = 0; lastErr = 0; pulses = 0;
    doneSeen = 0;
    cyc = 0;
    writeCount(cnt);
    while (!doneSeen && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (midWrite && cyc == 20) begin wrEn = 1'b1; wrData = 16'd70; end
      if (midWrite && cyc == 21) wrEn = 1'b0;
      outReady = (cyc % 3) != 0;
      if (outValid) begin
        if (outData != mem[8 + got]) mism++;
        if (outLast != (got == cnt - 13)) lastErr++;
        if (outReady) got++;
      end
      if (txDone) begin pulses++; doneSeen = 1; end
    end
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (txDone) pulses++;
      if (outValid) got++;
    end
    wrEn = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrData = '0; outReady = 1'b0;
    fillBuf();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(txCount == 0, "R9 count", txCount, 0);
    check(!outValid && !outLast, "R9 stream idle", outValid, 0);
    check(!txDone, "R9 done low", txDone, 0);

    // vector table: R2 R3 R4 R5 R6
    for (int v = 0; v < N_VEC; v++) begin
      runFrame(VEC_CNT[v], VEC_BAD[v], 1'b0);
      check(got == (VEC_OK[v] ? VEC_CNT[v] - 12 : 0), "R2/R3/R4/R5 byte count", got,
            VEC_OK[v] ? VEC_CNT[v] - 12 : 0);
      check(mism == 0, "R5 data", mism, 0);
      check(lastErr == 0, "R5 last flag", lastErr, 0);
      check(pulses == 1, "R7 one pulse", pulses, 1);
      check(int'(txCount) == (VEC_OK[v] ? 0 : VEC_CNT[v]), "R6 count after", txCount,
            VEC_OK[v] ? 0 : VEC_CNT[v]);
    end

    // R1: zero write stores zero, no attempt (count currently holds 100)
    writeCount(0);
    pulses = 0; got = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (txDone) pulses++;
      if (outValid) got++;
    end
    check(txCount == 0, "R1 zero stored", txCount, 0);
    check(pulses == 0 && got == 0, "R1 zero no start", pulses + got, 0);

    // R7: length reject pulse cycle
    writeCount(63);
    check(!txDone, "R7 not yet (cycle 1)", txDone, 0);
    @(negedge clk);
    check(txDone, "R7 pulse at cycle 2", txDone, 1);
    @(negedge clk);
    check(!txDone, "R7 pulse ends", txDone, 0);
    check(txCount == 63, "R2 rejected count kept", txCount, 63);

    // R8: write during send ignored
    runFrame(200, 8, 1'b1);
    check(got == 188, "R8 bytes unaffected", got, 188);
    check(mism == 0, "R8 data", mism, 0);
    check(pulses == 1, "R8 no extra attempt", pulses, 1);
    check(txCount == 0, "R8 count cleared not reloaded", txCount, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule